// File: doc/BRIEF.md
# Timer Clock Prescaler with Source Select

This block produces the count-enable tick for an 8-bit timer/counter. A 10-bit prescaler runs freely on a source clock. The source is the synchronous I/O clock, an asynchronous crystal clock, or an external clock pin. A 3-bit clock-select field picks one of three things: a tick on every source cycle, a tick on one of six power-of-two divided taps, or no ticks at all. Using the asynchronous source lets the timer keep time as a real-time counter, independent of the system clock.

Configuration is written on the I/O clock through a single write strobe. That write sets the clock-select code, the asynchronous-mode bit and the external-clock bit. It can also set a one-shot prescaler-clear request. The clear request zeroes the prescaler on the next source edge, so software can start a divided period from a known phase. The selected source and the stored configuration are visible on output ports.

Top module: `tick_prescaler`

## Requirements
- R1: While `rst_n` is low, the outputs are `tick`=0, `cs_rb`=000, `src_sel`=00 (I/O clock) and `psr_rb`=0.
- R2: Clock-select codes map to periods as follows: 001→1, 010→8, 011→32, 100→64, 101→128, 110→256, 111→1024 source cycles. After a clear, `tick` is high after every source edge whose edge count since the clear edge is a nonzero multiple of the period.
- R3: For any period above 1, each tick is exactly one source cycle wide.
- R4: With code 000, `tick` stays 0. The prescaler keeps counting on every source edge.
- R5: A write with `cfg_psr`=1 sets `psr_rb` for exactly one I/O cycle. The next source edge clears the prescaler and suppresses the tick, so the first divided tick comes one full period after the clearing edge.
- R6: With `cfg_async`=0, the prescaler runs on `clk_io` and `src_sel` reads 00. This holds whatever the value of `cfg_ext`.
- R7: With `cfg_async`=1 and `cfg_ext`=0, the prescaler runs on `xtal_clk` and `src_sel` reads 01.
- R8: With `cfg_async`=1 and `cfg_ext`=1, the prescaler runs on `ext_clk` and `src_sel` reads 10. The value 11 never appears on `src_sel`.
- R9: After a change from 000 to a nonzero code without a clear, the first tick lands on the next rollover of the running prescaler, counted from its last clear.
- R10: With code 001, `tick` is high after every source edge that does not clear the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_io | input | 1 | Synchronous I/O clock; clocks the configuration |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_clk | input | 1 | Asynchronous crystal oscillator clock |
| ext_clk | input | 1 | External clock driven onto the oscillator pin |
| cfg_we | input | 1 | Configuration write strobe (clk_io domain) |
| cfg_cs | input | 3 | Clock-select code to write |
| cfg_async | input | 1 | Asynchronous-mode bit to write |
| cfg_ext | input | 1 | External-clock bit to write |
| cfg_psr | input | 1 | Prescaler-clear request to write |
| tick | output | 1 | Count-enable pulse in the source-clock domain |
| src_sel | output | 2 | Selected source: 00 I/O, 01 crystal, 10 external |
| cs_rb | output | 3 | Stored clock-select code |
| psr_rb | output | 1 | Clear request readback; clears itself |

## Verification
The assertions check four rules on every source edge. The prescaler steps by one unless cleared. A clear edge leaves it at zero with no tick. The stop code never ticks. Code 001 always ticks, and ticks for longer periods last one cycle. On the I/O clock, the assertions check that the clear flag drops after one cycle and that the source code never takes the illegal value. Only the bench scenarios can show the exact tick phase after a clear for every code, the rollover timing when leaving stop, and which physical clock drives the count in each source mode.

// File: rtl/presc_pkg.sv
`timescale 1ns/1ps
package presc_pkg;

  localparam int PRE_W_DEF = 10;
  localparam int CS_W      = 3;
  localparam int NUM_CODES = 1 << CS_W;

  typedef enum logic [CS_W-1:0] {
    CS_STOP    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV32   = 3'd3,
    CS_DIV64   = 3'd4,
    CS_DIV128  = 3'd5,
    CS_DIV256  = 3'd6,
    CS_DIV1024 = 3'd7
  } cs_e;

  typedef enum logic [1:0] {
    SRC_IO   = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_EXT  = 2'd2
  } src_e;

  // log2 of the division ratio for each clock-select code
  function automatic int unsigned tap_shift(input logic [CS_W-1:0] code);
    case (code)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

  // low-bit mask whose all-zero state marks a rollover of the chosen tap
  function automatic logic [15:0] tap_mask(input logic [CS_W-1:0] code);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(tap_shift(code))) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic src_e pick_src(input logic async_bit, input logic ext_bit);
    if (!async_bit)   return SRC_IO;
    else if (ext_bit) return SRC_EXT;
    else              return SRC_XTAL;
  endfunction

endpackage

// File: rtl/presc_cfg_regs.sv
`timescale 1ns/1ps
module presc_cfg_regs
  import presc_pkg::*;
(
  input  logic            clk_io,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CS_W-1:0] cs_in,
  input  logic            async_in,
  input  logic            ext_in,
  input  logic            psr_in,
  output logic [CS_W-1:0] cs_q,
  output logic            async_q,
  output logic            ext_q,
  output logic            psr_q
);

  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= CS_STOP;
      async_q <= 1'b0;
      ext_q   <= 1'b0;
    end else if (we) begin
      cs_q    <= cs_in;
      async_q <= async_in;
      ext_q   <= ext_in;
    end
  end

  // one-shot clear request: lives for exactly one I/O cycle
  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) psr_q <= 1'b0;
    else        psr_q <= we & psr_in;
  end

endmodule

// File: rtl/presc_clk_mux.sv
`timescale 1ns/1ps
module presc_clk_mux
  import presc_pkg::*;
(
  input  logic clk_io,
  input  logic xtal_clk,
  input  logic ext_clk,
  input  logic async_q,
  input  logic ext_q,
  output src_e src_sel,
  output logic src_clk
);

  assign src_sel = pick_src(async_q, ext_q);

  always_comb begin
    case (src_sel)
      SRC_XTAL: src_clk = xtal_clk;
      SRC_EXT:  src_clk = ext_clk;
      default:  src_clk = clk_io;
    endcase
  end

endmodule

// File: rtl/presc_counter.sv
`timescale 1ns/1ps
module presc_counter #(
  parameter int PRE_W = presc_pkg::PRE_W_DEF
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [PRE_W-1:0] pre,
  output logic [PRE_W-1:0] pre_nxt
);

  assign pre_nxt = pre + 1'b1;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)     pre <= '0;
    else if (clear) pre <= '0;
    else            pre <= pre_nxt;
  end

endmodule

// File: rtl/presc_tap.sv
`timescale 1ns/1ps
module presc_tap
  import presc_pkg::*;
#(
  parameter int PRE_W = PRE_W_DEF
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic [CS_W-1:0]  cs,
  input  logic             clear,
  input  logic [PRE_W-1:0] pre_nxt,
  output logic             tick
);

  logic [NUM_CODES-1:0] tap_hit;

  // one rollover detector per clock-select code; code 0 never fires
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tap
    if (g == 0) begin : g_stop
      assign tap_hit[g] = 1'b0;
    end else begin : g_div
      localparam logic [15:0] MASK_W = tap_mask(CS_W'(g));
      localparam logic [PRE_W-1:0] MASK = MASK_W[PRE_W-1:0];
      assign tap_hit[g] = ((pre_nxt & MASK) == '0);
    end
  end

  logic tick_d;
  assign tick_d = !clear && tap_hit[cs];

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= tick_d;
  end

endmodule

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler
  import presc_pkg::*;
#(
  parameter int PRE_W = PRE_W_DEF
) (
  input  logic            clk_io,
  input  logic            rst_n,
  input  logic            xtal_clk,
  input  logic            ext_clk,
  input  logic            cfg_we,
  input  logic [CS_W-1:0] cfg_cs,
  input  logic            cfg_async,
  input  logic            cfg_ext,
  input  logic            cfg_psr,
  output logic            tick,
  output logic [1:0]      src_sel,
  output logic [CS_W-1:0] cs_rb,
  output logic            psr_rb
);

  logic [CS_W-1:0]  cs_q;
  logic             async_q;
  logic             ext_q;
  logic             psr_q;
  logic             src_clk;
  src_e             src_code;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] pre_nxt;

  presc_cfg_regs u_cfg (
    .clk_io   (clk_io),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .cs_in    (cfg_cs),
    .async_in (cfg_async),
    .ext_in   (cfg_ext),
    .psr_in   (cfg_psr),
    .cs_q     (cs_q),
    .async_q  (async_q),
    .ext_q    (ext_q),
    .psr_q    (psr_q)
  );

  presc_clk_mux u_mux (
    .clk_io   (clk_io),
    .xtal_clk (xtal_clk),
    .ext_clk  (ext_clk),
    .async_q  (async_q),
    .ext_q    (ext_q),
    .src_sel  (src_code),
    .src_clk  (src_clk)
  );

  presc_counter #(.PRE_W(PRE_W)) u_cnt (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .clear   (psr_q),
    .pre     (pre),
    .pre_nxt (pre_nxt)
  );

  presc_tap #(.PRE_W(PRE_W)) u_tap (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .cs      (cs_q),
    .clear   (psr_q),
    .pre_nxt (pre_nxt),
    .tick    (tick)
  );

  assign src_sel = src_code;
  assign cs_rb   = cs_q;
  assign psr_rb  = psr_q;

endmodule

// File: rtl/presc_checker.sv
`timescale 1ns/1ps
module presc_checker #(
  parameter int PRE_W = 10
) (
  input logic             src_clk,
  input logic             clk_io,
  input logic             rst_n,
  input logic [2:0]       cs_q,
  input logic             psr_q,
  input logic [PRE_W-1:0] pre,
  input logic             tick,
  input logic             cfg_we,
  input logic             cfg_psr,
  input logic [1:0]       src_sel
);

  assert_count_step_R4: assert property (@(posedge src_clk) disable iff (!rst_n)
    !psr_q |=> (pre == PRE_W'($past(pre) + 1'b1)));

  assert_clear_zero_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
    psr_q |=> (pre == '0));

  assert_clear_notick_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
    psr_q |=> !tick);

  assert_stop_quiet_R4: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cs_q == 3'd0) |=> !tick);

  assert_div1_always_R10: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cs_q == 3'd1 && !psr_q) |=> tick);

  assert_pulse_narrow_R3: assert property (@(posedge src_clk) disable iff (!rst_n)
    (tick && cs_q >= 3'd2) |=> (!tick || cs_q == 3'd1));

  assert_psr_selfclear_R5: assert property (@(posedge clk_io) disable iff (!rst_n)
    (psr_q && !(cfg_we && cfg_psr)) |=> !psr_q);

  assert_src_legal_R8: assert property (@(posedge clk_io) disable iff (!rst_n)
    src_sel != 2'b11);

endmodule

bind tick_prescaler presc_checker #(.PRE_W(PRE_W)) u_presc_chk (
  .src_clk (src_clk),
  .clk_io  (clk_io),
  .rst_n   (rst_n),
  .cs_q    (cs_q),
  .psr_q   (psr_q),
  .pre     (pre),
  .tick    (tick),
  .cfg_we  (cfg_we),
  .cfg_psr (cfg_psr),
  .src_sel (src_sel)
);

// File: tb/test_tick_prescaler.sv
`timescale 1ns/1ps
module test_tick_prescaler;

  logic clk_io = 1'b0;
  logic xtal_clk = 1'b0;
  logic ext_clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_cs = 3'd0;
  logic cfg_async = 1'b0;
  logic cfg_ext = 1'b0;
  logic cfg_psr = 1'b0;
  logic tick;
  logic [1:0] src_sel;
  logic [2:0] cs_rb;
  logic psr_rb;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5  clk_io   = ~clk_io;
  always #35 xtal_clk = ~xtal_clk;
  always #23 ext_clk  = ~ext_clk;

  tick_prescaler i_tick_prescaler (
    .clk_io(clk_io), .rst_n(rst_n), .xtal_clk(xtal_clk), .ext_clk(ext_clk),
    .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_async(cfg_async), .cfg_ext(cfg_ext),
    .cfg_psr(cfg_psr), .tick(tick), .src_sel(src_sel), .cs_rb(cs_rb), .psr_rb(psr_rb)
  );

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  function automatic int period_of(input int code);
    int p;
    p = 1;
    case (code)
      2: p = 8;
      3: p = 32;
      4: p = 64;
      5: p = 128;
      6: p = 256;
      7: p = 1024;
      default: p = 1;
    endcase
    return p;
  endfunction

  // called at a clk_io negedge; the write lands on the next posedge
  task automatic write_cfg(input int cs, input bit as, input bit ex, input bit ps);
    cfg_we = 1'b1; cfg_cs = 3'(cs); cfg_async = as; cfg_ext = ex; cfg_psr = ps;
    @(negedge clk_io);
    cfg_we = 1'b0; cfg_psr = 1'b0;
  endtask

  // clear plus a code on the I/O clock, then compare every cycle to the period
  task automatic run_sync(input int cs, input bit ex, input string req);
    int per;
    per = period_of(cs);
    write_cfg(cs, 1'b0, ex, 1'b1);
    chk(psr_rb == 1'b1, "R5", psr_rb, 1);
    chk(src_sel == 2'd0, "R6", src_sel, 0);
    @(negedge clk_io);
    chk(tick == 1'b0, "R5", tick, 0);
    chk(psr_rb == 1'b0, "R5", psr_rb, 0);
    for (int k = 1; k <= 2 * per + 3; k++) begin
      @(negedge clk_io);
      chk(tick == ((k % per) == 0), req, tick, int'((k % per) == 0));
    end
  endtask

  task automatic count_ticks_on(input bit use_ext, input int edges, input int expected, input string req);
    int seen;
    seen = 0;
    for (int e = 0; e < edges; e++) begin
      if (use_ext) @(negedge ext_clk); else @(negedge xtal_clk);
      if (tick) seen++;
    end
    chk(seen == expected, req, seen, expected);
  endtask

  initial begin
    repeat (3) @(negedge clk_io);
    // R1: outputs while reset is held
    chk(tick == 1'b0, "R1", tick, 0);
    chk(cs_rb == 3'd0, "R1", cs_rb, 0);
    chk(src_sel == 2'd0, "R1", src_sel, 0);
    chk(psr_rb == 1'b0, "R1", psr_rb, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_io);
    chk(tick == 1'b0, "R4", tick, 0);

    // R2 R3 R10: every nonzero code after a clear
    run_sync(1, 1'b0, "R10");
    for (int c = 2; c < 8; c++) begin
      run_sync(c, 1'b0, "R2");
      chk(cs_rb == 3'(c), "R2", cs_rb, c);
    end

    // R4: stop with a clear, then R9: resume without a clear
    write_cfg(0, 1'b0, 1'b0, 1'b1);
    for (int m = 1; m <= 14; m++) begin
      @(negedge clk_io);
      chk(tick == 1'b0, "R4", tick, 0);
    end
    write_cfg(2, 1'b0, 1'b0, 1'b0);
    chk(tick == 1'b0, "R9", tick, 0);
    for (int r = 16; r <= 40; r++) begin
      @(negedge clk_io);
      chk(tick == (((r - 1) % 8) == 0), "R9", tick, int'(((r - 1) % 8) == 0));
    end

    // R6: external bit without async mode is ignored
    run_sync(2, 1'b1, "R6");

    // R7: crystal source
    write_cfg(2, 1'b1, 1'b0, 1'b0);
    chk(src_sel == 2'd1, "R7", src_sel, 1);
    repeat (3) @(negedge xtal_clk);
    count_ticks_on(1'b0, 80, 10, "R7");

    // R8: external pin source
    @(negedge clk_io);
    write_cfg(3, 1'b1, 1'b1, 1'b0);
    chk(src_sel == 2'd2, "R8", src_sel, 2);
    repeat (3) @(negedge ext_clk);
    count_ticks_on(1'b1, 320, 10, "R8");

    // R1: reset mid-run returns to stop and the I/O clock
    @(negedge clk_io);
    rst_n = 1'b0;
    #1;
    chk(tick == 1'b0, "R1", tick, 0);
    chk(cs_rb == 3'd0, "R1", cs_rb, 0);
    chk(src_sel == 2'd0, "R1", src_sel, 0);
    @(negedge clk_io);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule